// File: doc/BRIEF.md
# PWM Timer Tick-Enable Tree

This block turns one peripheral clock into a set of single-cycle tick enables, one for each of five PWM timer channels. Each channel ticks either from a shared 8-bit prescaler followed by its own power-of-two divider, or from an external clock pin. The pin is synchronized into the peripheral clock domain and edge-detected. No derived or gated clock is created: every output is an enable, and the timers consume it in the same clock domain.

Two prescalers are shared across fixed groups of channels. Channels 0 and 1 use the low group, and channels 2 to 4 use the high group. The external pins are shared across the same groups. A single 4-bit field per channel picks both the divider and the source. Software programs the block through two word-wide configuration registers with a simple write strobe and a combinational read port. When a setting changes, the affected counters restart, so the first tick at the new rate comes after one full new period.

Top module: `pwm_tick_tree`

## Requirements
- R1: After reset, both configuration registers read as zero.
- R2: Register 0 (addr_i=0) holds prescaler value A in bits [7:0] and prescaler value B in bits [15:8]. Register 1 (addr_i=1) holds the 4-bit code of channel n in bits [4n+3:4n] for n = 0 to 4. All other bits read 0 and ignore writes.
- R3: With code c in 0..3, the channel ticks once every (P+1)·2^(c+1) clock cycles, where P is the prescaler value of its group.
- R4: Prescaler A drives channels 0 and 1. Prescaler B drives channels 2, 3 and 4.
- R5: Code 4 selects the external pin as the channel source, and so does every code from 5 to 15. In that case the prescaler path gives no ticks.
- R6: A rising edge on external pin 0 gives exactly one tick on every external-sourced channel among 0 and 1, in the second cycle after the edge is captured. Pin 1 does the same for channels 2 to 4, and neither pin affects the other group.
- R7: Writing a new prescaler value or a new channel code restarts the affected counters. The next tick comes exactly one full new period after the write, with no shortened tick.
- R8: A register 1 write that keeps a channel's code unchanged leaves that channel's tick phase undisturbed.
- R9: A tick enable is never high for two consecutive cycles while configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select (0 = prescalers, 1 = channel codes) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the register selected by addr_i |
| ext_clk_i | input | 2 | Asynchronous external clock pins, one per group |
| tick_o | output | 5 | Single-cycle tick enable per channel |

## Verification
A table of prescaler and code pairs is applied to one channel in each group at the same time. The first-tick and second-tick cycle counts separate the prescaler term from the divider term and show that the two groups are independent. Each row goes through a temporary prescaler value before the target, so every measurement starts from a restart. That exercises the full-period rule. External-source tests drive each pin alone and watch channels of both groups, which tells a wrong group mapping or a multi-cycle tick from correct behaviour. A mid-period rewrite of another channel's code shows whether the untouched channel keeps its phase.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int N_TMR   = 5;
  localparam int N_GRP   = 2;
  localparam int GRP0_N  = 2;
  localparam int PSC_W   = 8;
  localparam int CODE_W  = 4;
  localparam int DCNT_W  = 4;
  localparam int DATA_W  = 32;

  function automatic int grp_of(input int n);
    return (n < GRP0_N) ? 0 : 1;
  endfunction

  // last count of the divider: 2^(sel+1)-1
  function automatic logic [DCNT_W-1:0] div_last(input logic [1:0] sel);
    return DCNT_W'((1 << (sel + 1)) - 1);
  endfunction
endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         restart_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q == val_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == val_i);
endmodule

// File: rtl/ptt_ext_edge.sv
module ptt_ext_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic tick_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick_o = s2_q & ~s3_q;
endmodule

// File: rtl/ptt_chan_div.sv
module ptt_chan_div
  import pwm_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              psc_tick_i,
  input  logic              ext_tick_i,
  input  logic              restart_i,
  output logic              tick_o
);
  logic              ext_sel;
  logic [DCNT_W-1:0] lim;
  logic [DCNT_W-1:0] cnt_q;

  assign ext_sel = (code_i >= CODE_W'(4));
  assign lim     = div_last(code_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (psc_tick_i && !ext_sel)    cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = ext_sel ? ext_tick_i : (psc_tick_i && (cnt_q == lim));
endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree
  import pwm_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_GRP-1:0]  ext_clk_i,
  output logic [N_TMR-1:0]  tick_o
);
  localparam int PSC_BITS  = N_GRP * PSC_W;
  localparam int CODE_BITS = N_TMR * CODE_W;

  logic [PSC_BITS-1:0]  psc_q;
  logic [CODE_BITS-1:0] code_q;
  logic [N_GRP-1:0]     psc_chg, psc_tick, ext_tick;
  logic [N_TMR-1:0]     code_chg;
  logic                 wr_psc, wr_code;

  assign wr_psc  = wr_en_i && !addr_i;
  assign wr_code = wr_en_i &&  addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      code_q <= '0;
    end else begin
      if (wr_psc)  psc_q  <= wdata_i[PSC_BITS-1:0];
      if (wr_code) code_q <= wdata_i[CODE_BITS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) rdata_o[CODE_BITS-1:0] = code_q;
    else        rdata_o[PSC_BITS-1:0]  = psc_q;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign psc_chg[g] = wr_psc &&
                        (wdata_i[g*PSC_W +: PSC_W] != psc_q[g*PSC_W +: PSC_W]);

    ptt_prescaler #(.W(PSC_W)) u_psc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .val_i     (psc_q[g*PSC_W +: PSC_W]),
      .restart_i (psc_chg[g]),
      .tick_o    (psc_tick[g])
    );

    ptt_ext_edge u_ext (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_clk_i[g]),
      .tick_o (ext_tick[g])
    );
  end

  for (genvar n = 0; n < N_TMR; n++) begin : g_chan
    localparam int G = grp_of(n);

    assign code_chg[n] = wr_code &&
                         (wdata_i[n*CODE_W +: CODE_W] != code_q[n*CODE_W +: CODE_W]);

    ptt_chan_div u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (code_q[n*CODE_W +: CODE_W]),
      .psc_tick_i (psc_tick[G]),
      .ext_tick_i (ext_tick[G]),
      .restart_i  (code_chg[n] | psc_chg[G]),
      .tick_o     (tick_o[n])
    );
  end
endmodule

// File: rtl/pwm_tick_tree_chk.sv
module pwm_tick_tree_chk
  import pwm_tick_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic                      addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [N_TMR-1:0]          tick_o,
  input logic [N_GRP*PSC_W-1:0]    psc_q,
  input logic [N_TMR*CODE_W-1:0]   code_q
);
  for (genvar n = 0; n < N_TMR; n++) begin : g_t
    p_single_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[n] && !wr_en_i |=> !tick_o[n]);
  end

  p_code_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i |=> code_q == $past(wdata_i[N_TMR*CODE_W-1:0]));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(code_q) && $stable(psc_q));

  p_psc_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !addr_i && (wdata_i[PSC_W-1:0] != psc_q[PSC_W-1:0]) &&
    (code_q[CODE_W-1:0] < CODE_W'(4)) |=> !tick_o[0]);

  p_ext_group_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q[CODE_W-1:0] >= CODE_W'(4)) && (code_q[2*CODE_W-1:CODE_W] >= CODE_W'(4))
    |-> tick_o[0] == tick_o[1]);
endmodule

bind pwm_tick_tree pwm_tick_tree_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_o  (tick_o),
  .psc_q   (psc_q),
  .code_q  (code_q)
);

// File: tb/pwm_tick_tree_test.sv
`timescale 1ns/1ps
module pwm_tick_tree_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  ext_clk_i = '0;
  logic [4:0]  tick_o;

  int n_chk = 0;
  int n_err = 0;

  pwm_tick_tree uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_clk_i(ext_clk_i), .tick_o(tick_o)
  );

  always #5 clk_i = ~clk_i;

  // {psc A, psc B, code ch0, code ch2}
  localparam logic [23:0] TBL [6] = '{
    {8'd0, 8'd0, 4'd0, 4'd0},
    {8'd1, 8'd2, 4'd1, 4'd0},
    {8'd3, 8'd0, 4'd2, 4'd3},
    {8'd4, 8'd6, 4'd3, 4'd1},
    {8'd0, 8'd9, 4'd3, 4'd2},
    {8'd7, 8'd1, 4'd0, 4'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge (first cycle after the write)
  task automatic wr(input logic a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    addr_i = 1'b0; #1; chk("R1 reg0", int'(rdata_o), 0);
    addr_i = 1'b1; #1; chk("R1 reg1", int'(rdata_o), 0);
    @(negedge clk_i);

    // R2 layout and unused bits
    wr(1'b0, 32'hFFFF_A5C3);
    addr_i = 1'b0; #1; chk("R2 reg0", int'(rdata_o), 32'h0000_A5C3);
    @(negedge clk_i);
    wr(1'b1, 32'hFFF4_3210);
    addr_i = 1'b1; #1; chk("R2 reg1", int'(rdata_o), 32'h0004_3210);
    @(negedge clk_i);

    // R3 R4 R7 table walk: channel 0 on prescaler A, channel 2 on prescaler B
    foreach (TBL[i]) begin
      int pa = int'(TBL[i][23:16]);
      int pb = int'(TBL[i][15:8]);
      int ca = int'(TBL[i][7:4]);
      int cb = int'(TBL[i][3:0]);
      int ea = (pa + 1) * (1 << (ca + 1));
      int eb = (pb + 1) * (1 << (cb + 1));
      int f0 = -1, s0 = -1, f2 = -1, s2 = -1;
      int lim = 2 * ((ea > eb) ? ea : eb) + 4;
      wr(1'b1, {24'h0, 4'(cb), 4'h0, 4'(ca)});
      wr(1'b0, 32'h0000_FFFF);
      wr(1'b0, {16'h0, 8'(pb), 8'(pa)});
      for (int k = 1; k <= lim; k++) begin
        if (tick_o[0]) begin if (f0 < 0) f0 = k; else if (s0 < 0) s0 = k; end
        if (tick_o[2]) begin if (f2 < 0) f2 = k; else if (s2 < 0) s2 = k; end
        @(negedge clk_i);
      end
      chk("R7 ch0 first tick", f0, ea);
      chk("R3 ch0 period", s0, 2 * ea);
      chk("R4 ch2 first tick", f2, eb);
      chk("R3 ch2 period", s2, 2 * eb);
    end

    // R8: rewrite ch4 code mid-period; ch2 keeps phase, ch4 restarts (R7)
    begin
      int f2 = -1, f4 = -1;
      wr(1'b1, 32'h0000_0100);
      wr(1'b0, 32'h0000_FFFF);
      wr(1'b0, 32'h0000_0200);
      for (int k = 0; k < 100 && !tick_o[2]; k++) @(negedge clk_i);
      repeat (3) @(negedge clk_i);
      wr(1'b1, 32'h0002_0100);
      for (int c = 4; c <= 40; c++) begin
        if (tick_o[2] && f2 < 0) f2 = c;
        if (tick_o[4] && f4 < 0) f4 = c;
        @(negedge clk_i);
      end
      chk("R8 ch2 phase kept", f2, 12);
      chk("R7 ch4 restart", f4, 27);
    end

    // R5 R6 external sources: ch1 code 4, ch3 code 9
    wr(1'b1, 32'h0003_9343);
    wr(1'b0, 32'h0000_FFFF);
    wr(1'b0, 32'h0000_C8C8);
    repeat (4) @(negedge clk_i);
    begin
      int n1 = 0, k1 = -1, n3 = 0, n0 = 0;
      ext_clk_i[0] = 1'b1;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk_i);
        if (tick_o[1]) begin n1++; k1 = k; end
        if (tick_o[3]) n3++;
        if (tick_o[0]) n0++;
      end
      chk("R6 pin0 tick count ch1", n1, 1);
      chk("R6 pin0 tick cycle ch1", k1, 2);
      chk("R6 pin0 no tick ch3", n3, 0);
      chk("R5 ch0 ignores pin0", n0, 0);
      ext_clk_i[0] = 1'b0;
    end
    repeat (4) @(negedge clk_i);
    begin
      int n1 = 0, n3 = 0, k3 = -1, n2 = 0;
      ext_clk_i[1] = 1'b1;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk_i);
        if (tick_o[3]) begin n3++; k3 = k; end
        if (tick_o[1]) n1++;
        if (tick_o[2]) n2++;
      end
      chk("R9 pin1 single tick ch3", n3, 1);
      chk("R5 code9 ext ch3 cycle", k3, 2);
      chk("R6 pin1 no tick ch1", n1, 0);
      chk("R5 ch2 ignores pin1", n2, 0);
      ext_clk_i[1] = 1'b0;
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule